// File: doc/BRIEF.md
# Memory Region Security Filter

The filter decides, for every memory access presented to it, whether the access may proceed. Eight programmable windows, counted in 1 MB blocks, can each be placed in effect as secure. A ninth catch-all window stands for all memory lying outside every window that is in effect. A non-secure access that lands in protected memory is denied. Secure accesses always pass. A global bypass flag, which is set out of reset, makes all memory non-secure.

Software configures the filter through a single register write port. Every write carries its own 16-bit write-enable mask in the upper half of the data word, so single fields and single bits can be changed without a read-modify-write. The verdict for the address on the check port is formed combinationally and registered once. It appears on `chk_allow` one clock after the address.

Top module: `mem_region_guard`

## Requirements
- R1: Only address bits 31 down to 20 take part in the comparison. The low 20 bits never change the verdict.
- R2: A window's end field names the last 1 MB block it contains, so the end is inclusive. With start 0 and end 0 the window covers 0x0 to 0xFFFFF, and 0x100000 lies outside it.
- R3: Window n uses register index 2n and register index 2n+1. Index 2n holds the start block in bits 11:0, the secure-select flag in bit 12 and the enable flag in bit 13. Index 2n+1 holds the end block in bits 11:0.
- R4: Register index 16 holds the catch-all secure-select flag in bit 0, the catch-all enable flag in bit 1 and the global bypass flag in bit 2.
- R5: A window protects memory only while its secure-select flag and its enable flag are both 1. Either flag alone has no effect.
- R6: In a write, bits 31:16 are a per-bit enable for bits 15:0. A stored bit changes only where its mask bit is 1.
- R7: While global bypass is 1, every access is allowed, whatever the windows hold.
- R8: An access with `chk_secure` = 1 is always allowed.
- R9: When windows overlap, a non-secure access is denied if any protecting window contains it.
- R10: When the catch-all flags are both 1, a non-secure access outside all protecting windows is denied.
- R11: After reset, every field is zero, both catch-all flags are 0, global bypass is 1, and `chk_allow` is 1.
- R12: `chk_allow` reflects the address and attribute of the previous cycle. A configuration write first affects the verdict for addresses presented in the cycle after the write.
- R13: Writes to register indices 17 to 31 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Register index of the write |
| cfg_wdata | input | 32 | Mask in bits 31:16, data in bits 15:0 |
| chk_addr | input | 32 | Byte address of the access under check |
| chk_secure | input | 1 | 1 when the access is secure |
| chk_allow | output | 1 | Registered verdict: 1 allow, 0 deny |

## Verification
The hardest state to reach is an overlap in which protecting windows and half-configured windows (only one flag set) cover the same block, while a masked write changes a single flag in the same cycle as a check on that block. The bench builds windows one flag at a time through masked writes, so every intermediate state is checked. It then issues writes and checks together in the same cycle to confirm the one-cycle ordering. A long random phase follows, with mixed masks, out-of-range indices and addresses near window edges, and a behavioural model is compared against the design on every clock.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  localparam int CTL_SEL_BIT = 12;
  localparam int CTL_EN_BIT  = 13;
  localparam int GLB_CSEL    = 0;
  localparam int GLB_CEN     = 1;
  localparam int GLB_BYP     = 2;

  // masked half-word update: upper half enables lower half bit by bit
  function automatic logic [15:0] masked_write(input logic [15:0] old_v,
                                               input logic [31:0] wr);
    return (old_v & ~wr[31:16]) | (wr[15:0] & wr[31:16]);
  endfunction

  // inclusive block range test
  function automatic logic mb_in_range(input logic [15:0] mb,
                                       input logic [15:0] lo,
                                       input logic [15:0] hi);
    return (mb >= lo) && (mb <= hi);
  endfunction
endpackage

// File: rtl/mrg_cfg_regs.sv
module mrg_cfg_regs #(
  parameter int N_RGN     = 8,
  parameter int MB_W      = 12,
  parameter int NUM_REGS  = 2*N_RGN+1,
  parameter int REG_IDX_W = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [REG_IDX_W-1:0]           cfg_idx,
  input  logic [31:0]                    cfg_wdata,
  output logic [N_RGN-1:0][MB_W-1:0]     rgn_lo,
  output logic [N_RGN-1:0][MB_W-1:0]     rgn_hi,
  output logic [N_RGN-1:0]               rgn_on,
  output logic                           catch_on,
  output logic                           bypass
);
  import mrg_pkg::*;
  localparam int GLB_IDX = 2*N_RGN;
  localparam logic [15:0] GLB_RST = 16'(1) << GLB_BYP;

  logic [NUM_REGS-1:0][15:0] regs;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam logic [15:0] RST_V = (k == GLB_IDX) ? GLB_RST : 16'h0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[k] <= RST_V;
      else if (cfg_we && cfg_idx == REG_IDX_W'(k))
        regs[k] <= masked_write(regs[k], cfg_wdata);
    end
  end

  for (genvar n = 0; n < N_RGN; n++) begin : g_fld
    assign rgn_lo[n] = regs[2*n][MB_W-1:0];
    assign rgn_hi[n] = regs[2*n+1][MB_W-1:0];
    assign rgn_on[n] = regs[2*n][CTL_SEL_BIT] & regs[2*n][CTL_EN_BIT];
  end

  assign catch_on = regs[GLB_IDX][GLB_CSEL] & regs[GLB_IDX][GLB_CEN];
  assign bypass   = regs[GLB_IDX][GLB_BYP];

  logic wr_in_map;
  assign wr_in_map = cfg_we && (32'(cfg_idx) < NUM_REGS);

  assert_mask_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in_map |=> (((regs[$past(cfg_idx)] ^ $past(regs[cfg_idx]))
                     & ~$past(cfg_wdata[31:16])) == 16'h0));

  assert_outside_map_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !wr_in_map) |=> $stable(regs));
endmodule

// File: rtl/mrg_region_match.sv
module mrg_region_match #(
  parameter int N_RGN = 8,
  parameter int MB_W  = 12
) (
  input  logic [MB_W-1:0]              mb,
  input  logic [N_RGN-1:0][MB_W-1:0]   rgn_lo,
  input  logic [N_RGN-1:0][MB_W-1:0]   rgn_hi,
  input  logic [N_RGN-1:0]             rgn_on,
  output logic [N_RGN-1:0]             hit
);
  import mrg_pkg::*;
  for (genvar n = 0; n < N_RGN; n++) begin : g_cmp
    assign hit[n] = rgn_on[n] &&
                    mb_in_range(16'(mb), 16'(rgn_lo[n]), 16'(rgn_hi[n]));
  end
endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard #(
  parameter int N_RGN    = 8,
  parameter int ADDR_W   = 32,
  parameter int MB_SHIFT = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [4:0]           cfg_idx,
  input  logic [31:0]          cfg_wdata,
  input  logic [ADDR_W-1:0]    chk_addr,
  input  logic                 chk_secure,
  output logic                 chk_allow
);
  localparam int MB_W = ADDR_W - MB_SHIFT;

  logic [N_RGN-1:0][MB_W-1:0] rgn_lo, rgn_hi;
  logic [N_RGN-1:0]           rgn_on, hit;
  logic                       catch_on, bypass;
  logic                       any_hit, deny_now;
  logic [MB_W-1:0]            mb;

  mrg_cfg_regs #(.N_RGN(N_RGN), .MB_W(MB_W), .REG_IDX_W(5)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .rgn_lo(rgn_lo), .rgn_hi(rgn_hi),
    .rgn_on(rgn_on), .catch_on(catch_on), .bypass(bypass)
  );

  assign mb = chk_addr[ADDR_W-1:MB_SHIFT];

  mrg_region_match #(.N_RGN(N_RGN), .MB_W(MB_W)) i_match (
    .mb(mb), .rgn_lo(rgn_lo), .rgn_hi(rgn_hi), .rgn_on(rgn_on), .hit(hit)
  );

  assign any_hit  = |hit;
  // catch-all covers what no protecting window covers; a window hit denies anyway
  assign deny_now = !chk_secure && !bypass && (any_hit || catch_on);

  always_ff @(posedge clk) begin
    if (!rst_n) chk_allow <= 1'b1;
    else        chk_allow <= !deny_now;
  end

  assert_secure_allowed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_secure |=> chk_allow);

  assert_bypass_allows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> chk_allow);

  assert_deny_needs_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_hit && !catch_on) |=> chk_allow);

  assert_hit_denies_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && !bypass && !chk_secure) |=> !chk_allow);
endmodule

// File: tb/test_mem_region_guard.sv
module test_mem_region_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] chk_addr = '0;
  logic chk_secure = 1'b0;
  logic chk_allow;

  always #2.5 clk = ~clk;

  mem_region_guard i_mem_region_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .chk_addr(chk_addr), .chk_secure(chk_secure),
    .chk_allow(chk_allow)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [15:0] m [0:16];
  bit    pend_exp = 1'b1;
  string pend_tag = "R11";

  function automatic bit model_allow(input logic [31:0] a, input bit sec);
    int blk = int'(a >> 20);
    if (sec) return 1'b1;
    if (m[16][2]) return 1'b1;
    for (int w = 0; w < 8; w++)
      if (m[2*w][13] && m[2*w][12] &&
          blk >= int'(m[2*w][11:0]) && blk <= int'(m[2*w+1][11:0]))
        return 1'b0;
    if (m[16][0] && m[16][1]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic step(input bit we, input int idx, input logic [31:0] wd,
                      input logic [31:0] a, input bit sec, input string tag);
    @(negedge clk);
    vectors++;
    if (chk_allow !== pend_exp) begin
      miscompares++;
      $display("FAIL %s: chk_allow=%0b expected=%0b", pend_tag, chk_allow, pend_exp);
    end
    cfg_we = we; cfg_idx = 5'(idx); cfg_wdata = wd;
    chk_addr = a; chk_secure = sec;
    pend_exp = model_allow(a, sec);
    pend_tag = tag;
    if (we && idx <= 16)
      for (int b = 0; b < 16; b++)
        if (wd[16+b]) m[idx][b] = wd[b];
  endtask

  task automatic chk(input logic [31:0] a, input bit sec, input string tag);
    step(1'b0, 0, 32'h0, a, sec, tag);
  endtask

  task automatic wr(input int idx, input logic [31:0] wd, input string tag);
    step(1'b1, idx, wd, 32'h0, 1'b0, tag);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 17; i++) m[i] = 16'h0;
    m[16] = 16'h0004;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R11: reset state allows everything
    chk(32'h0000_0000, 1'b0, "R11");
    chk(32'hFFF0_0000, 1'b0, "R11");
    // R3 window 0 = block 0..0; bypass still on -> R7
    wr(0, 32'hFFFF_3000, "R3");
    wr(1, 32'hFFFF_0000, "R3");
    chk(32'h0000_0000, 1'b0, "R7");
    // R4 clear bypass only
    wr(16, 32'h0004_0000, "R4");
    chk(32'h0000_0000, 1'b0, "R2");
    chk(32'h000F_FFFF, 1'b0, "R1");
    chk(32'h0010_0000, 1'b0, "R2");
    chk(32'h0000_0000, 1'b1, "R8");
    // window 3: blocks 0x10..0x1F, flags added one at a time (R5)
    wr(6, 32'h0FFF_0010, "R3");
    wr(7, 32'h0FFF_001F, "R3");
    chk(32'h0150_0000, 1'b0, "R5");
    wr(6, 32'h1000_1000, "R5");
    chk(32'h0150_0000, 1'b0, "R5");
    wr(6, 32'h3000_2000, "R5");
    chk(32'h0150_0000, 1'b0, "R5");
    wr(6, 32'h1000_0000, "R5");
    chk(32'h0150_0000, 1'b0, "R5");
    wr(6, 32'h1000_1000, "R5");
    chk(32'h01FF_FFFF, 1'b0, "R2");
    chk(32'h0200_0000, 1'b0, "R2");
    chk(32'h00FF_FFFF, 1'b0, "R2");
    chk(32'h0100_0000, 1'b0, "R1");
    // R6 zero mask changes nothing; single-bit mask clears secure-select
    wr(6, 32'h0000_FFFF, "R6");
    wr(7, 32'h0000_0000, "R6");
    chk(32'h0150_0000, 1'b0, "R6");
    wr(6, 32'h1000_0000, "R6");
    chk(32'h0150_0000, 1'b0, "R6");
    // R9 overlap: window 5 protects 0x10..0x30, window 7 enable only at 0x20
    wr(10, 32'hFFFF_3010, "R9");
    wr(11, 32'hFFFF_0030, "R9");
    wr(14, 32'hFFFF_2020, "R9");
    wr(15, 32'hFFFF_0020, "R9");
    chk(32'h0200_0000, 1'b0, "R9");
    chk(32'h0310_0000, 1'b0, "R9");
    // R10 catch-all
    wr(16, 32'h0003_0003, "R10");
    chk(32'h8000_0000, 1'b0, "R10");
    chk(32'h8000_0000, 1'b1, "R8");
    wr(16, 32'h0001_0000, "R10");
    chk(32'h8000_0000, 1'b0, "R10");
    // R13 out-of-map writes
    step(1'b1, 20, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, "R13");
    step(1'b1, 31, 32'hFFFF_FFFF, 32'h0200_0000, 1'b0, "R13");
    chk(32'h8000_0000, 1'b0, "R13");
    // R12 write and check in the same cycle
    step(1'b1, 16, 32'h0004_0004, 32'h0200_0000, 1'b0, "R12");
    chk(32'h0200_0000, 1'b0, "R12");
    step(1'b1, 16, 32'h0004_0000, 32'h0200_0000, 1'b0, "R12");
    chk(32'h0200_0000, 1'b0, "R12");
    // random phase
    for (int i = 0; i < 2000; i++) begin
      bit we = ($urandom % 3) == 0;
      int idx = int'($urandom % 20);
      logic [31:0] wd = {16'($urandom), 4'h0, 12'($urandom % 64)};
      logic [31:0] a = {6'h0, 6'($urandom), 20'($urandom)};
      if (($urandom % 8) == 0) a = $urandom;
      step(we, idx, wd, a, ($urandom % 5) == 0, "R9");
    end
    chk(32'h0, 1'b0, "R12");
    finish_run();
  end
endmodule